// File: doc/BRIEF.md
# Three-Source Maskable Interrupt Controller

This block collects interrupt requests for a small 8-bit microcontroller core and decides when the instruction sequencer must branch to the interrupt vector. Three sources feed it: an external interrupt pin with a selectable active edge, a one-cycle overflow pulse from the system timer, and a change detector on the upper four bits of a general-purpose input port. Each source sets a sticky flag in a single 8-bit control register. The register also holds one enable bit per source, an edge-select bit and a global enable bit.

When the global enable is set and at least one flag has its enable bit set, the block raises a one-cycle vector request to the sequencer and clears the global enable in the same clock. The sequencer then saves the return address and jumps to the fixed vector. Hardware never clears a flag. Software finds the source by polling the flags, clears them by writing the register, and leaves the handler with a return strobe that sets the global enable again. The port-change source compares the synchronized pins with a copy taken at the last read of the port, so any read re-arms it.

Top module: `irq_hub`

## Requirements
- R1: Control register layout: bit 0 port-change flag, bit 1 external-pin flag, bit 2 timer flag, bit 3 port-change enable, bit 4 external-pin enable, bit 5 timer enable, bit 6 edge select (1 = rising, 0 = falling), bit 7 global enable. After reset the register reads 0x40 and vec_req is low.
- R2: An edge of ext_pin with the polarity that bit 6 selects sets bit 1 within three clock edges. An edge of the other polarity leaves the flag unchanged.
- R3: vec_req goes high only in the cycle after one where bit 7 was set and a flag in bits 2:0 had its matching enable in bits 5:3 set.
- R4: The clock edge that raises vec_req also clears bit 7.
- R5: One acceptance gives exactly one vec_req cycle, even when several enabled flags are pending together.
- R6: A flag falls only through a register write. Hardware never clears a flag.
- R7: A one-cycle pulse on tmr_ovf sets bit 2 at the next clock edge.
- R8: When the synchronized port_hi differs from the snapshot taken at the last port_rd strobe, bit 0 is set. The snapshot is 0 after reset. Once a read has made the snapshot equal to the pins, a cleared flag stays clear.
- R9: A pulse on ret_strobe sets bit 7. If an enabled flag is still pending, a new request follows.
- R10: When a hardware source sets a flag in the same cycle as a write that clears it, the flag ends up set.
- R11: A flag whose enable bit is 0 never produces vec_req, even with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| port_hi | input | 4 | Watched upper bits of the input port (asynchronous) |
| port_rd | input | 1 | Port read strobe; takes the snapshot |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| ret_strobe | input | 1 | Return-from-interrupt strobe |
| reg_rdata | output | 8 | Control register contents |
| vec_req | output | 1 | One-cycle request to branch to the vector |

## Verification
The assertions assume that tmr_ovf arrives as a single-cycle pulse from logic in the same clock domain, and that ret_strobe and reg_wr are driven synchronously. The asynchronous inputs ext_pin and port_hi pass through synchronizers before any property looks at their effect. The stimulus changes the pins only after a clock edge and holds each level for several cycles, so every edge is seen by the detector. It issues port_rd only while the pins are stable, so the snapshot matches a known value.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  // number of interrupt sources
  localparam int NSRC     = 3;
  // source index order inside the flag and enable fields
  localparam int SRC_CHG  = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_TMR  = 2;
  // control register field positions
  localparam int FLG_LO   = 0;
  localparam int EN_LO    = NSRC;
  localparam int EDGE_BIT = 2 * NSRC;
  localparam int GEN_BIT  = 2 * NSRC + 1;
  localparam int CTL_W    = 2 * NSRC + 2;
  // reset value: rising edge selected, all else clear
  localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(1) << EDGE_BIT;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_hit
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  // synchronizer stages followed by one history stage
  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_chain
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  logic now_lvl, old_lvl;
  assign now_lvl = chain_q[STAGES-1];
  assign old_lvl = chain_q[STAGES];

  always_comb begin
    if (rise_sel) edge_hit = now_lvl & ~old_lvl;
    else          edge_hit = ~now_lvl & old_lvl;
  end
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int WATCH_W = 4,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WATCH_W-1:0] pins,
  input  logic               rd_strobe,
  output logic               mismatch
);
  logic [WATCH_W-1:0] sync_q [STAGES];
  logic [WATCH_W-1:0] snap_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= '0;
          else     sync_q[s] <= pins;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= '0;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  // snapshot of the synchronized pins, taken on each read
  always_ff @(posedge clk) begin
    if (rst)            snap_q <= '0;
    else if (rd_strobe) snap_q <= sync_q[STAGES-1];
  end

  assign mismatch = (sync_q[STAGES-1] != snap_q);
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  src_vec_t         src_set,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             ret,
  output logic [CTL_W-1:0] ctl_q,
  output logic             vec_req
);
  src_vec_t   flags, enables;
  logic       gen;
  logic       take;
  logic [CTL_W-1:0] ctl_d;

  assign flags   = ctl_q[FLG_LO +: NSRC];
  assign enables = ctl_q[EN_LO  +: NSRC];
  assign gen     = ctl_q[GEN_BIT];
  assign take    = gen & (|(flags & enables));

  always_comb begin
    ctl_d = ctl_q;
    if (wr) ctl_d = wdata;
    // hardware set wins over a software clear in the same cycle
    ctl_d[FLG_LO +: NSRC] = ctl_d[FLG_LO +: NSRC] | src_set;
    if (take)     ctl_d[GEN_BIT] = 1'b0;
    else if (wr)  ctl_d[GEN_BIT] = wdata[GEN_BIT];
    else if (ret) ctl_d[GEN_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= CTL_RESET;
      vec_req <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      vec_req <= take;
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int WATCH_W   = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_pin,
  input  logic               tmr_ovf,
  input  logic [WATCH_W-1:0] port_hi,
  input  logic               port_rd,
  input  logic               reg_wr,
  input  logic [CTL_W-1:0]   reg_wdata,
  input  logic               ret_strobe,
  output logic [CTL_W-1:0]   reg_rdata,
  output logic               vec_req
);
  logic     ext_hit, chg_hit;
  src_vec_t src_set;
  logic [CTL_W-1:0] ctl_q;

  irq_edge_det #(.STAGES(SYNC_STGS)) u_ext (
    .clk      (clk),
    .rst      (rst),
    .pin      (ext_pin),
    .rise_sel (ctl_q[EDGE_BIT]),
    .edge_hit (ext_hit)
  );

  irq_port_watch #(.WATCH_W(WATCH_W), .STAGES(SYNC_STGS)) u_chg (
    .clk       (clk),
    .rst       (rst),
    .pins      (port_hi),
    .rd_strobe (port_rd),
    .mismatch  (chg_hit)
  );

  always_comb begin
    src_set          = '0;
    src_set[SRC_CHG] = chg_hit;
    src_set[SRC_EXT] = ext_hit;
    src_set[SRC_TMR] = tmr_ovf;
  end

  irq_ctl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .src_set (src_set),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .ret     (ret_strobe),
    .ctl_q   (ctl_q),
    .vec_req (vec_req)
  );

  assign reg_rdata = ctl_q;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tmr_ovf,
  input logic             reg_wr,
  input logic             ret_strobe,
  input logic [CTL_W-1:0] reg_rdata,
  input logic             vec_req
);
  // R3
  req_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> $past(reg_rdata[GEN_BIT] &&
      (|(reg_rdata[FLG_LO +: NSRC] & reg_rdata[EN_LO +: NSRC]))));

  // R4
  gen_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> !reg_rdata[GEN_BIT]);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |=> !vec_req);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr) |->
      (($past(reg_rdata[FLG_LO +: NSRC]) & ~reg_rdata[FLG_LO +: NSRC]) == '0));

  // R7
  tmr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf |=> reg_rdata[FLG_LO + SRC_TMR]);

  // R9
  gen_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[GEN_BIT]) |-> $past(reg_wr || ret_strobe));
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tmr_ovf    (tmr_ovf),
  .reg_wr     (reg_wr),
  .ret_strobe (ret_strobe),
  .reg_rdata  (reg_rdata),
  .vec_req    (vec_req)
);

// File: tb/tb_irq_hub.sv
`timescale 1ns/1ps
module tb_irq_hub;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_pin = 1'b0;
  logic       tmr_ovf = 1'b0;
  logic [3:0] port_hi = 4'h0;
  logic       port_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       ret_strobe = 1'b0;
  logic [7:0] reg_rdata;
  logic       vec_req;

  irq_hub dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .port_hi(port_hi), .port_rd(port_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .ret_strobe(ret_strobe),
    .reg_rdata(reg_rdata), .vec_req(vec_req)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit         is_vec;
    logic [7:0] exp;
    string      req;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  int vec_cnt = 0;
  bit done = 0;

  // monitor: counts requests, then pops and compares expected items
  always @(negedge clk) begin
    if (!rst && vec_req) vec_cnt++;
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      act = it.is_vec ? 8'(vec_cnt) : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s %s actual=%h expected=%h", it.req,
                 it.is_vec ? "vec_count" : "reg", act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic exp_reg(input logic [7:0] e, input string r);
    sb_item_t it;
    it.is_vec = 0; it.exp = e; it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic exp_vec(input int e, input string r);
    sb_item_t it;
    it.is_vec = 1; it.exp = 8'(e); it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic wr_reg(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_tmr();
    tmr_ovf = 1'b1;
    step(1);
    tmr_ovf = 1'b0;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    exp_reg(8'h40, "R1"); exp_vec(0, "R1"); step(1);

    // R7 timer flag next edge; R11 no request while disabled
    pulse_tmr();
    exp_reg(8'h44, "R7"); step(3);
    exp_vec(0, "R11"); step(1);

    // R2 rising edge selected
    ext_pin = 1'b1; step(4);
    exp_reg(8'h46, "R2"); step(1);
    ext_pin = 1'b0; step(4);
    exp_reg(8'h46, "R2"); step(1);

    // R6 software clears the flags
    wr_reg(8'h40);
    exp_reg(8'h40, "R6"); step(1);

    // R2 falling edge selected
    wr_reg(8'h00);
    ext_pin = 1'b1; step(4);
    exp_reg(8'h00, "R2"); step(1);
    ext_pin = 1'b0; step(4);
    exp_reg(8'h02, "R2"); step(1);
    wr_reg(8'h00);

    // R8 port change on watched bits
    port_hi = 4'h5; step(4);
    exp_reg(8'h01, "R8"); step(1);
    port_rd = 1'b1; step(1); port_rd = 1'b0;
    wr_reg(8'h00);
    step(3);
    exp_reg(8'h00, "R8"); step(1);

    // R3 R4 request on enabled timer flag
    wr_reg(8'hA0);
    pulse_tmr();
    step(3);
    exp_vec(1, "R3"); exp_reg(8'h24, "R4"); step(3);
    exp_vec(1, "R5"); step(1);

    // R9 return re-arms, still pending gives another request
    ret_strobe = 1'b1; step(1); ret_strobe = 1'b0;
    step(3);
    exp_vec(2, "R9"); exp_reg(8'h24, "R9"); step(1);
    wr_reg(8'h20);
    ret_strobe = 1'b1; step(1); ret_strobe = 1'b0;
    step(3);
    exp_reg(8'hA0, "R9"); exp_vec(2, "R9"); step(1);

    // R5 several pending, one request
    wr_reg(8'hBF);
    step(4);
    exp_vec(3, "R5"); exp_reg(8'h3F, "R5"); step(1);

    // R10 hardware set beats software clear
    reg_wr = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1;
    step(1);
    reg_wr = 1'b0; tmr_ovf = 1'b0;
    exp_reg(8'h04, "R10"); step(1);

    // R11 flags without enables under global enable
    wr_reg(8'h87);
    step(3);
    exp_vec(3, "R11"); exp_reg(8'h87, "R11"); step(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule